// File: doc/BRIEF.md
# Masked Error Status and Halt Unit

This block gathers the error events of a random-number peripheral and turns them into a sticky status word, one error interrupt line and one halt line for the processing engine. Four error sources are watched: an illegal value written to the mode register, an access to an illegal address inside the peripheral's space, a read of the empty output FIFO, and an internal fault. Each source has its own single-cycle event input.

A mask register holds one bit per source. A masked source is dropped entirely and leaves no trace. An unmasked source latches its status bit, which raises the interrupt and freezes the engine through the halt output. Both stay up until software clears every latched bit by writing ones to the status register. Software reaches the mask and status registers through a simple word-addressed read/write port with combinational read data.

Top module: `err_halt_unit`

## Requirements
- R1: After reset, the mask and status registers read 0 and irq_o and halt_o are low.
- R2: An event whose mask bit is 1 leaves its status bit unchanged and raises neither irq_o nor halt_o.
- R3: An event whose mask bit is 0 sets its status bit at the next rising clock edge, and irq_o and halt_o are high from that edge on.
- R4: The status word places mode error at bit 31, address error at bit 30, output FIFO underflow at bit 25 and internal error at bit 20.
- R5: All other status and mask bits read 0. A mask write keeps only bits 31, 30, 25 and 20, and the mask uses the same bit positions as the status word.
- R6: Status bits are sticky. Writing 1 to a bit of the status register (offset 0x4) clears it, and writing 0 leaves it unchanged.
- R7: irq_o and halt_o are high exactly while any status bit is set. halt_o drops on the edge that clears the last set bit.
- R8: An unmasked event in the same cycle as a write-one-clear of its own bit leaves the bit set.
- R9: A mask write (offset 0x0) neither clears nor sets status bits that are already latched.
- R10: A status write does not change the mask, and a read from any offset other than 0x0 or 0x4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset (0x0 mask, 0x4 status) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| mode_err_i | input | 1 | Illegal mode write event |
| addr_err_i | input | 1 | Illegal address event |
| fifo_unf_err_i | input | 1 | Empty output FIFO read event |
| int_err_i | input | 1 | Internal fault event |
| irq_o | output | 1 | Error interrupt |
| halt_o | output | 1 | Engine halt |

## Verification
The hardest case to produce from the ports is an event that arrives on the very cycle software clears the same bit. The second hardest is a mask change made while a bit is already latched. The directed part of the stimulus times a status write and an event pulse into one cycle. It also flips the mask around latched bits and checks that the status word stays as it was. A long random phase then drives events, mask writes and clears together at high density. A behavioural model, compared on every clock, catches collisions and partial clears that no directed sequence names.

// File: rtl/err_halt_pkg.sv
package err_halt_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_SRC = 4;

  typedef enum int unsigned {
    SRC_MODE = 0,
    SRC_ADDR = 1,
    SRC_UNF  = 2,
    SRC_INT  = 3
  } err_src_e;

  // status/mask bit position per source; decoded by software
  localparam int unsigned SRC_BIT [NUM_SRC] = '{31, 30, 25, 20};

  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NUM_SRC); i++) m[SRC_BIT[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask();
endpackage

// File: rtl/err_sticky_cell.sv
module err_sticky_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic q_o
);
  logic set;
  assign set = evt_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set)   q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !mask_i) |=> q_o);
  p_masked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && !clr_i) |=> (q_o == $past(q_o)));
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(evt_i && !mask_i)) |=> !q_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i && !mask_i) |=> q_o);
endmodule

// File: rtl/err_mask_reg.sv
module err_mask_reg #(
  parameter int unsigned             DATA_W = 32,
  parameter logic [DATA_W-1:0]       IMPL   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i & IMPL;
  end

  p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mask_o & ~IMPL) == '0));
  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/err_rd_mux.sv
module err_rd_mux #(
  parameter int unsigned          DATA_W   = 32,
  parameter int unsigned          ADDR_W   = 4,
  parameter logic [ADDR_W-1:0]    MASK_OFS = '0,
  parameter logic [ADDR_W-1:0]    STAT_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      MASK_OFS: rdata_o = mask_i;
      STAT_OFS: rdata_o = stat_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/err_halt_unit.sv
module err_halt_unit
  import err_halt_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              mode_err_i,
  input  logic              addr_err_i,
  input  logic              fifo_unf_err_i,
  input  logic              int_err_i,
  output logic              irq_o,
  output logic              halt_o
);
  logic [NUM_SRC-1:0] src_evt, src_q, src_mask;
  logic [DATA_W-1:0]  mask_q, stat_w;
  logic               mask_we, stat_we;

  assign mask_we = reg_we_i && (reg_addr_i == MASK_OFS);
  assign stat_we = reg_we_i && (reg_addr_i == STAT_OFS);

  always_comb begin
    src_evt           = '0;
    src_evt[SRC_MODE] = mode_err_i;
    src_evt[SRC_ADDR] = addr_err_i;
    src_evt[SRC_UNF]  = fifo_unf_err_i;
    src_evt[SRC_INT]  = int_err_i;
  end

  err_mask_reg #(.DATA_W(DATA_W), .IMPL(IMPL_MASK)) u_mask (
    .clk_i, .rst_ni,
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_src
    assign src_mask[i] = mask_q[SRC_BIT[i]];
    err_sticky_cell u_cell (
      .clk_i, .rst_ni,
      .evt_i  (src_evt[i]),
      .mask_i (src_mask[i]),
      .clr_i  (stat_we & reg_wdata_i[SRC_BIT[i]]),
      .q_o    (src_q[i])
    );
  end

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < int'(NUM_SRC); i++) stat_w[SRC_BIT[i]] = src_q[i];
  end

  err_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS)) u_rd (
    .addr_i  (reg_addr_i),
    .mask_i  (mask_q),
    .stat_i  (stat_w),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o  = |src_q;
  assign halt_o = |src_q;

  p_rise_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(src_evt & ~src_mask)));
  p_halt_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> $past(stat_we));
  p_mask_no_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_evt == '0) |=> ((src_q & ~$past(src_q)) == '0));
  always_comb begin
    if (rst_ni) p_rsvd_zero_r5: assert ((reg_rdata_o & ~IMPL_MASK) == '0);
  end
endmodule

// File: tb/err_halt_unit_bench.sv
module err_halt_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'hC210_0000;
  localparam logic [3:0]  A_MASK = 4'h0, A_STAT = 4'h4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        e_mode = 0, e_addr = 0, e_unf = 0, e_int = 0;
  logic        irq, halt;
  int          checks = 0, errors = 0;
  bit          done = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_halt_unit u_err_halt_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mode_err_i(e_mode), .addr_err_i(e_addr), .fifo_unf_err_i(e_unf),
    .int_err_i(e_int), .irq_o(irq), .halt_o(halt));

  // reference model
  logic [31:0] m_mask, m_stat;
  logic [31:0] ev;
  always_comb ev = {e_mode, e_addr, 4'b0, e_unf, 4'b0, e_int, 20'b0};
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= 0; m_stat <= 0;
    end else begin
      logic [31:0] nxt;
      nxt = m_stat;
      if (we && addr == A_STAT) nxt = nxt & ~wdata;
      nxt = nxt | (ev & ~m_mask);
      m_stat <= nxt;
      if (we && addr == A_MASK) m_mask <= wdata & IMPL;
    end
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    if (a == A_MASK) return m_mask;
    if (a == A_STAT) return m_stat;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare against model
  task automatic step(logic w, logic [3:0] a, logic [31:0] d, logic [3:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    {e_mode, e_addr, e_unf, e_int} = e;
    #1;
    chk("R7 irq model", {31'b0, irq}, {31'b0, |m_stat});
    chk("R7 halt model", {31'b0, halt}, {31'b0, |m_stat});
    chk("R4 rdata model", rdata, m_read(a));
    rd = rdata;
  endtask

  task automatic rd_reg(logic [3:0] a);
    step(0, a, 0, 4'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(A_MASK); chk("R1 mask reset", rd, 0);
    rd_reg(A_STAT); chk("R1 stat reset", rd, 0);
    chk("R1 irq/halt reset", {30'b0, irq, halt}, 0);

    // R3/R4 each source alone, then W1C (R6), halt drop (R7)
    for (int s = 0; s < 4; s++) begin
      logic [31:0] pos;
      pos = (s == 0) ? 32'h8000_0000 : (s == 1) ? 32'h4000_0000 :
            (s == 2) ? 32'h0200_0000 : 32'h0010_0000;
      step(0, A_STAT, 0, 4'b1000 >> s);
      rd_reg(A_STAT);
      chk("R4 bit position", rd, pos);
      chk("R3 irq/halt set", {30'b0, irq, halt}, 2'b11);
      step(1, A_STAT, 0, 4'b0);            // write 0: no effect
      rd_reg(A_STAT);
      chk("R6 write zero keeps", rd, pos);
      step(1, A_STAT, pos, 4'b0);
      rd_reg(A_STAT);
      chk("R6 w1c", rd, 0);
      chk("R7 halt dropped", {31'b0, halt}, 0);
    end

    // R5 mask write keeps implemented bits only
    step(1, A_MASK, 32'hFFFF_FFFF, 4'b0);
    rd_reg(A_MASK);
    chk("R5 mask readback", rd, IMPL);
    // R2 masked events dropped
    step(0, A_STAT, 0, 4'b1111);
    step(0, A_STAT, 0, 4'b1111);
    rd_reg(A_STAT);
    chk("R2 masked status", rd, 0);
    chk("R2 masked irq/halt", {30'b0, irq, halt}, 0);

    // R9 mask change not retroactive
    step(1, A_MASK, 0, 4'b0);
    step(0, A_STAT, 0, 4'b0101);
    step(1, A_MASK, IMPL, 4'b0);
    rd_reg(A_STAT);
    chk("R9 mask set keeps status", rd, 32'h4010_0000);
    step(1, A_MASK, 0, 4'b0);
    rd_reg(A_STAT);
    chk("R9 mask clear sets nothing", rd, 32'h4010_0000);

    // R7 partial clear keeps halt
    step(1, A_STAT, 32'h4000_0000, 4'b0);
    rd_reg(A_STAT);
    chk("R7 partial clear halt", {31'b0, halt}, 1);
    // R8 event and clear same cycle
    step(1, A_STAT, 32'h0010_0000, 4'b0001);
    rd_reg(A_STAT);
    chk("R8 set wins", rd, 32'h0010_0000);
    step(1, A_STAT, 32'hFFFF_FFFF, 4'b0);
    rd_reg(A_STAT);
    chk("R7 last clear halt low", {30'b0, irq, halt}, 0);

    // R10 status write leaves mask, unmapped reads zero
    step(1, A_MASK, 32'h0200_0000, 4'b0);
    step(1, A_STAT, 32'hFFFF_FFFF, 4'b0);
    rd_reg(A_MASK);
    chk("R10 mask unchanged", rd, 32'h0200_0000);
    step(0, A_STAT, 0, 4'b1111);
    rd_reg(4'h8);
    chk("R10 unmapped read", rd, 0);
    rd_reg(A_STAT);
    chk("R2 partial mask", rd, 32'hC010_0000);

    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = ($urandom_range(0, 3) == 0) ? A_MASK : A_STAT;
      d = $urandom;
      step($urandom_range(0, 2) == 0, a, d, 4'($urandom) & 4'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule